// File: doc/BRIEF.md
# Dual-Write Video RAM Steering

This block sits between the CPU memory cycles aimed at the four upper RAM pages (pages 4 to 7) and two memories: the main RAM and a separate 64 KB video RAM. In normal operation every CPU write to those pages lands in both memories. The video copy goes through a one-entry posted buffer. That buffer drains into the single video RAM port whenever the display fetch and CPU video reads leave the port free, so the CPU only sees a wait when a second video write arrives while the first is still held behind a display fetch.

An 8-bit mode register decides how writes are spread. It can block video writes per 8 KB or 16 KB region, keep writes out of main RAM, send CPU reads to the video RAM, select a double-width display in which page 5 forms the left half and page 7 the right half, and hand the video RAM write path to a one-bit-per-pixel serial capture stream. The display timing generator is outside the block. It shows up only as a fetch request with a screen offset and a half-screen flag.

Pages 4..7 are presented as `cpu_page` 0..3. The video RAM address is `{page index, 14-bit offset}`, so page 5 is index 1 and page 7 is index 3.

Top module: `vram_steer`

## Requirements
- R1: A CPU write (`cpu_req` and `cpu_wr`) to any page with no blocking bit set raises `mram_we` in the same cycle and enters the posted buffer. The buffered byte is then written to video RAM address `{cpu_page, cpu_off}` on the first later cycle in which the port is not taken by a fetch or a CPU video read.
- R2: With mode bit 0 set, video writes to page index 1 with `cpu_off[13]`=0 are dropped. With mode bit 1 set, the same applies to page index 3.
- R3: With mode bit 2 set, video writes with `cpu_off[13]`=1 to page index 1 or 3 are dropped. With mode bit 3 set, video writes to page index 0 or 2 are dropped.
- R4: With mode bit 4 set, `mram_we` stays low, and CPU writes reach only the video RAM.
- R5: With mode bit 5 set, a CPU read raises `rd_vram` and reads video RAM address `{cpu_page, cpu_off}` on the port in that cycle. With bit 5 clear, `rd_vram` stays low.
- R6: While `disp_req` is high, the port performs a read at the display address, and any pending buffered write is held.
- R7: With mode bit 6 clear, the display address is `{legacy_scr, 1'b1, disp_off}`, which shows page 5 or page 7.
- R8: With mode bit 6 set, the display address is `{disp_half, 1'b1, disp_off}`: page 5 on the left half and page 7 on the right half.
- R9: `cpu_wait` rises only while `disp_req` is high. It rises either for a CPU video read or for an unblocked CPU video write that arrives while the buffer is full. During the wait, `mram_we` and `rd_vram` stay low and nothing is accepted.
- R10: With mode bit 7 set, CPU writes never enter the video path. Each run of 8 `cap_valid` bits, taken first bit as MSB, forms a byte that is buffered for `cap_addr` given with the eighth bit. The byte is dropped if the buffer cannot take it in that cycle. While bit 7 is clear, capture input is ignored and the bit count restarts.
- R11: `ctrl_we` loads `ctrl_wdata` into the mode register, which is readable on `ctrl_q` from the next cycle. A mode change applies to accesses from the next cycle on.
- R12: After reset the mode register is 0, the buffer is empty, and no port access, wait or main RAM write occurs without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Mode register write strobe |
| ctrl_wdata | input | 8 | Mode register write data |
| ctrl_q | output | 8 | Mode register contents |
| legacy_scr | input | 1 | Screen select from the legacy paging register |
| cpu_req | input | 1 | CPU cycle to pages 4-7 |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_page | input | 2 | Page index (0 = page 4 ... 3 = page 7) |
| cpu_off | input | 14 | Byte offset within the page |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wait | output | 1 | Hold the CPU cycle |
| mram_we | output | 1 | Main RAM write enable |
| rd_vram | output | 1 | CPU read data comes from video RAM |
| disp_req | input | 1 | Display fetch request |
| disp_half | input | 1 | Right half of a double-width line |
| disp_off | input | 14 | Display offset within the screen page |
| cap_valid | input | 1 | Serial capture pixel strobe |
| cap_bit | input | 1 | Serial capture pixel |
| cap_addr | input | 16 | Video RAM address for the completed capture byte |
| vram_en | output | 1 | Video RAM port access |
| vram_we | output | 1 | Video RAM port write |
| vram_addr | output | 16 | Video RAM port address |
| vram_wdata | output | 8 | Video RAM port write data |

## Verification
The bench uses the default 14-bit offset and 8-bit data. At that size, every page index, both 8 KB halves and each mode bit can be reached with random stimulus. Fetch requests are dense enough that a write often lands behind a held entry, which reaches the wait path. Capture phases run for thousands of cycles with bit 7 set, so the byte assembly wraps many times and bytes collide with a busy buffer.

// File: rtl/vram_steer.sv
module vram_steer #(
  parameter int OFFW = 14,
  parameter int DW = 8,
  localparam int AW = OFFW + 2,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_q,
  input  logic          legacy_scr,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_page,
  input  logic [OFFW-1:0] cpu_off,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_wait,
  output logic          mram_we,
  output logic          rd_vram,
  input  logic          disp_req,
  input  logic          disp_half,
  input  logic [OFFW-1:0] disp_off,
  input  logic          cap_valid,
  input  logic          cap_bit,
  input  logic [AW-1:0] cap_addr,
  output logic          vram_en,
  output logic          vram_we,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_wdata
);

  logic [7:0]    ctrl;
  logic          buf_v;
  logic [AW-1:0] buf_a;
  logic [DW-1:0] buf_d;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          vblk;

  always_comb begin
    case (cpu_page)
      2'd1:    vblk = cpu_off[OFFW-1] ? ctrl[2] : ctrl[0];
      2'd3:    vblk = cpu_off[OFFW-1] ? ctrl[2] : ctrl[1];
      default: vblk = ctrl[3];
    endcase
  end

  wire cpu_vw   = cpu_req & cpu_wr & ~ctrl[7] & ~vblk;
  wire cpu_vr   = cpu_req & ~cpu_wr & ctrl[5];
  wire drain    = buf_v & ~disp_req & ~cpu_vr;
  wire room     = ~buf_v | drain;
  wire cap_full = ctrl[7] & cap_valid & (cnt == CW'(DW - 1));
  wire load_cpu = cpu_vw & room;
  wire load_cap = cap_full & room;
  wire [1:0] dpg = {ctrl[6] ? disp_half : legacy_scr, 1'b1};

  assign ctrl_q   = ctrl;
  assign cpu_wait = (cpu_vw & ~room) | (cpu_vr & disp_req);
  assign mram_we  = cpu_req & cpu_wr & ~ctrl[4] & ~cpu_wait;
  assign rd_vram  = cpu_vr & ~cpu_wait;

  always_comb begin
    vram_en    = 1'b0;
    vram_we    = 1'b0;
    vram_addr  = '0;
    vram_wdata = '0;
    if (disp_req) begin
      vram_en   = 1'b1;
      vram_addr = {dpg, disp_off};
    end else if (cpu_vr) begin
      vram_en   = 1'b1;
      vram_addr = {cpu_page, cpu_off};
    end else if (buf_v) begin
      vram_en    = 1'b1;
      vram_we    = 1'b1;
      vram_addr  = buf_a;
      vram_wdata = buf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      buf_v <= 1'b0;
      buf_a <= '0;
      buf_d <= '0;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      if (ctrl_we) ctrl <= ctrl_wdata;
      if (load_cpu) begin
        buf_v <= 1'b1;
        buf_a <= {cpu_page, cpu_off};
        buf_d <= cpu_wdata;
      end else if (load_cap) begin
        buf_v <= 1'b1;
        buf_a <= cap_addr;
        buf_d <= {sh[DW-2:0], cap_bit};
      end else if (drain) begin
        buf_v <= 1'b0;
      end
      if (!ctrl[7]) begin
        cnt <= '0;
      end else if (cap_valid) begin
        cnt <= (cnt == CW'(DW - 1)) ? '0 : cnt + 1'b1;
        sh  <= {sh[DW-2:0], cap_bit};
      end
    end
  end

endmodule

module vram_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic [7:0] ctrl_q,
  input logic       cpu_wait,
  input logic       mram_we,
  input logic       rd_vram,
  input logic       disp_req,
  input logic       vram_en,
  input logic       vram_we
);
  // R6
  fetch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req |-> (vram_en && !vram_we));
  // R9
  wait_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> disp_req);
  // R9
  wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (!mram_we && !rd_vram));
  // R4
  main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> !mram_we);
  // R11
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(ctrl_wdata)));
endmodule

bind vram_steer vram_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .ctrl_q(ctrl_q), .cpu_wait(cpu_wait), .mram_we(mram_we), .rd_vram(rd_vram),
  .disp_req(disp_req), .vram_en(vram_en), .vram_we(vram_we)
);

// File: tb/vram_steer_test.sv
module vram_steer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, legacy_scr = 0, cpu_req = 0, cpu_wr = 0;
  logic [7:0] ctrl_wdata = 0, cpu_wdata = 0;
  logic [1:0] cpu_page = 0;
  logic [13:0] cpu_off = 0, disp_off = 0;
  logic disp_req = 0, disp_half = 0, cap_valid = 0, cap_bit = 0;
  logic [15:0] cap_addr = 0;
  logic [7:0] ctrl_q, vram_wdata;
  logic cpu_wait, mram_we, rd_vram, vram_en, vram_we;
  logic [15:0] vram_addr;

  int tests = 0, fails = 0;
  int m_ctrl = 0, m_bv = 0, m_ba = 0, m_bd = 0, m_cnt = 0, m_sh = 0;

  always #5 clk = ~clk;

  vram_steer uut (.*);

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step_model(int phase);
    int blocked, vw, vr, wt, free_port, drain, room, e_en, e_we, e_a, e_d, pg, capb;
    @(negedge clk);
    ctrl_we    = ($urandom_range(0, 15) == 0);
    ctrl_wdata = $urandom;
    if (phase == 0) ctrl_wdata[7] = 1'b0;
    if (phase == 2) ctrl_wdata[7] = 1'b1;
    cpu_req    = $urandom_range(0, 2) != 0;
    cpu_wr     = $urandom_range(0, 2) != 0;
    cpu_page   = $urandom;
    cpu_off    = $urandom;
    cpu_wdata  = $urandom;
    disp_req   = $urandom_range(0, 2) == 0;
    disp_half  = $urandom;
    disp_off   = $urandom;
    legacy_scr = $urandom;
    cap_valid  = $urandom;
    cap_bit    = $urandom;
    cap_addr   = $urandom;
    #1;
    // video blocking per R2/R3
    if (cpu_page == 0 || cpu_page == 2) blocked = m_ctrl[3];
    else if (cpu_off >= 14'h2000) blocked = m_ctrl[2];
    else if (cpu_page == 1) blocked = m_ctrl[0];
    else blocked = m_ctrl[1];
    vw = cpu_req && cpu_wr && !m_ctrl[7] && !blocked;
    vr = cpu_req && !cpu_wr && m_ctrl[5];
    free_port = !disp_req && !vr;
    drain = m_bv && free_port;
    room = !m_bv || drain;
    wt = (vw && !room) || (vr && disp_req);
    e_en = 0; e_we = 0; e_a = 0; e_d = 0;
    if (disp_req) begin
      pg = m_ctrl[6] ? (disp_half ? 3 : 1) : (legacy_scr ? 3 : 1);
      e_en = 1; e_a = pg * 16384 + disp_off;
    end else if (vr) begin
      e_en = 1; e_a = cpu_page * 16384 + cpu_off;
    end else if (m_bv) begin
      e_en = 1; e_we = 1; e_a = m_ba; e_d = m_bd;
    end
    check("R11", "ctrl_q", ctrl_q, m_ctrl);
    check("R9", "cpu_wait", cpu_wait, wt);
    check("R4", "mram_we", mram_we, cpu_req && cpu_wr && !m_ctrl[4] && !wt);
    check("R5", "rd_vram", rd_vram, vr && !wt);
    check("R6", "vram_en", vram_en, e_en);
    check("R1", "vram_we", vram_we, e_we);
    check(disp_req ? (m_ctrl[6] ? "R8" : "R7") : "R1", "vram_addr", vram_addr, e_a);
    check("R10", "vram_wdata", vram_wdata, e_d);
    // next state
    capb = ((m_sh << 1) | cap_bit) & 255;
    if (vw && room) begin
      m_bv = 1; m_ba = cpu_page * 16384 + cpu_off; m_bd = cpu_wdata;
    end else if (m_ctrl[7] && cap_valid && m_cnt == 7 && room) begin
      m_bv = 1; m_ba = cap_addr; m_bd = capb;
    end else if (drain) m_bv = 0;
    if (!m_ctrl[7]) m_cnt = 0;
    else if (cap_valid) begin
      m_cnt = (m_cnt + 1) % 8;
      m_sh = capb;
    end
    if (ctrl_we) m_ctrl = ctrl_wdata;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12", "ctrl_q", ctrl_q, 0);
    check("R12", "vram_en", vram_en, 0);
    check("R12", "cpu_wait", cpu_wait, 0);
    check("R12", "mram_we", mram_we, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4000; i++) step_model(0);
    for (int i = 0; i < 3000; i++) step_model(1);
    for (int i = 0; i < 3000; i++) step_model(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL R12 watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule